// File: doc/BRIEF.md
# SHA-256 Message Padder and Packer

This block sits in front of a SHA-256 compression core. Message bytes arrive one per cycle on a valid/ready input. They are packed big-endian into a 512-bit block, four bytes to a 32-bit word. When all 64 byte positions are filled, the block is offered to the core on a valid/ready output. Byte input stalls until the core takes the block.

A finish request ends the message. The block then feeds the standard SHA-256 padding through the same byte path as the data. The padding is a 0x80 marker, zero fill, and a 64-bit big-endian length trailer. The trailer value comes from the running byte count that also positions every byte. This produces one or two further blocks. After the trailer, the block is ready for a new message with a byte count of zero.

A message-start pulse can preload the byte count. An outer hash stage that has already handled 96 bytes (64 key bytes plus a 32-byte digest) therefore gets the correct block position and trailer length. A byte that would take the bit length to 2^32 raises a sticky error flag.

Top module: `sha_pad_packer`

## Requirements
- R1: After reset, `blk_valid` is 0, `in_ready` is 1 and `len_err` is 0.
- R2: Byte position k of a block (k = 0..63) appears at `blk_data[511-8k -: 8]`. Word 0 is therefore the top 32 bits, and within a word the earlier byte is the more significant.
- R3: When the 64th byte position is written, `blk_valid` rises and `blk_data` is held unchanged until `blk_ready` is seen high. While `blk_valid` is 1, `in_ready` is 0.
- R4: The byte 0x80 is placed in the position directly after the last message byte.
- R5: Zero bytes follow the marker until the position reaches 56. If the marker lands at position 56 or later, an extra block is produced.
- R6: The last 8 positions of the final block are the trailer: four zero bytes, then the 32-bit bit length, most significant byte first. The bit length is (preload + message bytes) × 8, modulo 2^32.
- R7: After the trailer, the byte count is zero. A following message sent without a start pulse is padded for its own length alone.
- R8: A `msg_start` pulse does the following:
  - loads the byte count from `msg_preload`;
  - clears the block contents and any pending block;
  - clears `len_err`.
  The first byte then lands at position `msg_preload` mod 64, and the positions before it hold zero.
- R9: If `finish_i` is accepted in the same cycle as a byte, that byte is the last message byte.
- R10: Accepting a byte while the byte count is 2^29−1 sets `len_err`. The flag stays set until `msg_start` or reset.
- R11: From the cycle after `finish_i` is accepted until the trailer is written, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Begin a new message with a preloaded count |
| msg_preload | input | 29 | Byte count loaded by `msg_start` |
| in_valid | input | 1 | Message byte is valid |
| in_byte | input | 8 | Message byte |
| in_ready | output | 1 | Block accepts a byte or a finish request |
| finish_i | input | 1 | End-of-message request |
| blk_valid | output | 1 | Full block offered to the core |
| blk_data | output | 512 | Packed block, byte position 0 in the top bits |
| blk_ready | input | 1 | Core takes the block |
| len_err | output | 1 | Bit length reached 2^32 |

## Verification
The assertions assume the following about the inputs:
- `msg_start` is a lone pulse.
- `in_valid` and `finish_i` are driven only against the block's own `in_ready`, so nothing arrives while a block waits or padding runs.
- `blk_ready` may be low for any number of cycles.

The bench drives every byte and finish request at the falling edge and holds it until `in_ready` is seen high. It never pulses `msg_start` while a transfer is in flight. It holds `blk_ready` low for several cycles in one scenario to exercise the stall.

// File: rtl/sha_pad_pkg.sv
`timescale 1ns/1ps
package sha_pad_pkg;
  localparam int unsigned BYTE_W = 8;

  // Source of the byte written into the block each cycle
  typedef enum logic [1:0] {
    PH_DATA = 2'd0,   // message bytes from the input
    PH_MARK = 2'd1,   // single 0x80 marker
    PH_ZERO = 2'd2,   // zero fill up to the trailer position
    PH_LEN  = 2'd3    // 64-bit length trailer
  } pad_phase_e;
endpackage

// File: rtl/sha_pad_buf.sv
`timescale 1ns/1ps
// Block register: byte-addressed write, whole-block read, full flag
module sha_pad_buf #(
  parameter  int unsigned BLK_BYTES = 64,
  localparam int unsigned POS_W     = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W     = BLK_BYTES * sha_pad_pkg::BYTE_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           wr_en,
  input  logic [POS_W-1:0]               wr_pos,
  input  logic [sha_pad_pkg::BYTE_W-1:0] wr_byte,
  input  logic                           wr_last,
  input  logic                           take,
  output logic                           full,
  output logic [BLK_W-1:0]               data
);
  localparam int unsigned BW = sha_pad_pkg::BYTE_W;

  // One register lane per byte position; position 0 is the most significant
  logic [BW-1:0] lane_q [BLK_BYTES];

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lane_q[b] <= '0;
      end else if (wr_en && (wr_pos == POS_W'(b))) begin
        lane_q[b] <= wr_byte;
      end
    end
    assign data[BLK_W-1-BW*b -: BW] = lane_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
    end else if (wr_en && wr_last) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sha_pad_seq.sv
`timescale 1ns/1ps
// Byte counter, padding phase sequencer and write-byte selection
module sha_pad_seq
  import sha_pad_pkg::*;
#(
  parameter  int unsigned BLK_BYTES = 64,
  parameter  int unsigned LEN_W     = 32,
  localparam int unsigned POS_W     = $clog2(BLK_BYTES),
  localparam int unsigned CNT_W     = LEN_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  preload,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              finish,
  input  logic              full,
  output logic              in_ready,
  output logic              wr_en,
  output logic [POS_W-1:0]  wr_pos,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_last,
  output logic              len_err
);
  localparam int unsigned TRAIL_B  = 8;                 // 64-bit trailer
  localparam int unsigned LEN_B    = LEN_W / BYTE_W;    // nonzero trailer bytes
  localparam int unsigned TI_W     = $clog2(TRAIL_B);
  localparam int unsigned MARK_END = BLK_BYTES - TRAIL_B;

  pad_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;

  logic              take_byte, pad_go, fin_go;
  logic [POS_W-1:0]  pos, pos_nx;
  logic [TI_W-1:0]   tidx;
  logic [BYTE_W-1:0] pad_byte;

  assign pos       = cnt_q[POS_W-1:0];
  assign pos_nx    = pos + 1'b1;
  assign tidx      = pos[TI_W-1:0];
  assign in_ready  = (phase_q == PH_DATA) && !full;
  assign take_byte = in_valid && in_ready && !start;
  assign fin_go    = finish && in_ready && !start;
  assign pad_go    = (phase_q != PH_DATA) && !full && !start;
  assign wr_en     = take_byte || pad_go;
  assign wr_pos    = pos;
  assign wr_last   = (pos == POS_W'(BLK_BYTES - 1));
  assign len_err   = err_q;

  always_comb begin
    pad_byte = '0;
    unique case (phase_q)
      PH_MARK: pad_byte = 8'h80;
      PH_LEN: begin
        if (tidx >= TI_W'(TRAIL_B - LEN_B)) begin
          pad_byte = BYTE_W'(len_q >> (BYTE_W * (TRAIL_B - 1 - int'(tidx))));
        end
      end
      default: pad_byte = '0;
    endcase
  end

  assign wr_byte = take_byte ? in_byte : pad_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_DATA;
      cnt_q   <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else if (start) begin
      phase_q <= PH_DATA;
      cnt_q   <= preload;
      err_q   <= 1'b0;
    end else begin
      if (take_byte && (cnt_q == '1)) begin
        err_q <= 1'b1;
      end
      if (fin_go) begin
        len_q   <= {cnt_q + CNT_W'(take_byte), 3'b000};
        phase_q <= PH_MARK;
      end
      if (wr_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (pad_go) begin
        unique case (phase_q)
          PH_MARK: phase_q <= (pos_nx == POS_W'(MARK_END)) ? PH_LEN : PH_ZERO;
          PH_ZERO: if (pos_nx == POS_W'(MARK_END)) phase_q <= PH_LEN;
          PH_LEN: begin
            if (wr_last) begin
              phase_q <= PH_DATA;
              cnt_q   <= '0;
            end
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/sha_pad_packer.sv
`timescale 1ns/1ps
module sha_pad_packer #(
  parameter  int unsigned BLK_BYTES = 64,
  parameter  int unsigned LEN_W     = 32,
  localparam int unsigned BLK_W     = BLK_BYTES * 8,
  localparam int unsigned CNT_W     = LEN_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_start,
  input  logic [CNT_W-1:0] msg_preload,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             finish_i,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk_data,
  input  logic             blk_ready,
  output logic             len_err
);
  localparam int unsigned POS_W = $clog2(BLK_BYTES);

  logic             wr_en, wr_last, full;
  logic [POS_W-1:0] wr_pos;
  logic [7:0]       wr_byte;

  sha_pad_seq #(.BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (msg_start),
    .preload  (msg_preload),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .finish   (finish_i),
    .full     (full),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_pos   (wr_pos),
    .wr_byte  (wr_byte),
    .wr_last  (wr_last),
    .len_err  (len_err)
  );

  sha_pad_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr     (msg_start),
    .wr_en   (wr_en),
    .wr_pos  (wr_pos),
    .wr_byte (wr_byte),
    .wr_last (wr_last),
    .take    (full && blk_ready),
    .full    (full),
    .data    (blk_data)
  );

  assign blk_valid = full;
endmodule

// File: rtl/sha_pad_packer_chk.sv
`timescale 1ns/1ps
module sha_pad_packer_chk #(
  parameter int unsigned BLK_W = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_start,
  input logic             in_ready,
  input logic             finish_i,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic [BLK_W-1:0] blk_data,
  input logic             len_err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!blk_valid && in_ready && !len_err));

  assert_block_held_R3: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready && !msg_start) |=> (blk_valid && $stable(blk_data)));

  assert_stall_on_block_R3: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> !in_ready);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (len_err && !msg_start) |=> len_err);

  assert_pad_blocks_input_R11: assert property (@(posedge clk) disable iff (rst)
    (finish_i && in_ready && !msg_start) |=> !in_ready);
endmodule

bind sha_pad_packer sha_pad_packer_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_start (msg_start),
  .in_ready  (in_ready),
  .finish_i  (finish_i),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_data  (blk_data),
  .len_err   (len_err)
);

// File: tb/sha_pad_packer_bench.sv
`timescale 1ns/1ps
module sha_pad_packer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         msg_start = 1'b0;
  logic [28:0]  msg_preload = '0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = '0;
  logic         in_ready;
  logic         finish_i = 1'b0;
  logic         blk_valid;
  logic [511:0] blk_data;
  logic         blk_ready = 1'b1;
  logic         len_err;

  int checks = 0;
  int fails  = 0;
  int nblk   = 0;
  int exp_n  = 0;
  logic [511:0] got [8];
  logic [7:0]   msg   [256];
  logic [7:0]   exp_b [512];

  always #2.5 clk = ~clk;

  sha_pad_packer u_sha_pad_packer (
    .clk(clk), .rst(rst), .msg_start(msg_start), .msg_preload(msg_preload),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .finish_i(finish_i), .blk_valid(blk_valid), .blk_data(blk_data),
    .blk_ready(blk_ready), .len_err(len_err)
  );

  // Block collector: samples half a nanosecond before each rising edge
  initial forever begin
    @(negedge clk); #2;
    if (!rst && blk_valid && blk_ready) begin
      if (nblk < 8) got[nblk] = blk_data;
      nblk++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than 150000", wd);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic chk_blk(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic make_msg(input int n, input int seed);
    for (int i = 0; i < n; i++) msg[i] = 8'(i * 29 + seed * 7 + 1);
  endtask

  // Expected padded stream built from the requirements
  task automatic build_exp(input int n, input longint pre);
    int idx = 0;
    longint tot;
    longint bits;
    for (int i = 0; i < int'(pre % 64); i++) begin exp_b[idx] = 8'h00; idx++; end
    for (int i = 0; i < n; i++) begin exp_b[idx] = msg[i]; idx++; end
    exp_b[idx] = 8'h80; idx++;
    tot = pre + n + 1;
    while ((tot % 64) != 56) begin exp_b[idx] = 8'h00; idx++; tot++; end
    bits = ((pre + n) * 8) % 64'h1_0000_0000;
    for (int i = 0; i < 4; i++) begin exp_b[idx] = 8'h00; idx++; end
    for (int i = 3; i >= 0; i--) begin exp_b[idx] = 8'(bits >> (8 * i)); idx++; end
    exp_n = idx / 64;
  endtask

  function automatic logic [511:0] exp_block(input int b);
    logic [511:0] e;
    for (int k = 0; k < 64; k++) e[511 - 8 * k -: 8] = exp_b[b * 64 + k];
    return e;
  endfunction

  task automatic pulse_start(input longint pre);
    @(negedge clk); msg_start = 1'b1; msg_preload = 29'(pre);
    @(negedge clk); msg_start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input bit valid, input bit fin);
    @(negedge clk); in_valid = valid; in_byte = b; finish_i = fin;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0; finish_i = 1'b0;
  endtask

  task automatic send(input string name, input int n, input bit together);
    for (int i = 0; i < n; i++) put(msg[i], 1'b1, together && (i == n - 1));
    if (!(together && n > 0)) put(8'h00, 1'b0, 1'b1);
    chk(in_ready == 1'b0, "R11", {name, " in_ready after finish"}, in_ready, 0);
  endtask

  task automatic wait_blocks(input string req, input string name);
    int t = 0;
    while (nblk < exp_n && t < 2000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    chk(nblk == exp_n, req, {name, " block count"}, nblk, exp_n);
    if (nblk == exp_n)
      for (int b = 0; b < exp_n; b++)
        chk_blk(got[b] == exp_block(b), req, $sformatf("%s block %0d", name, b), got[b], exp_block(b));
  endtask

  task automatic run_case(input string name, input string req, input int n,
                          input longint pre, input bit do_start, input bit together, input int seed);
    make_msg(n, seed);
    build_exp(n, pre);
    nblk = 0;
    if (do_start) pulse_start(pre);
    send(name, n, together);
    wait_blocks(req, name);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(blk_valid == 1'b0, "R1", "blk_valid after reset", blk_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(len_err == 1'b0, "R1", "len_err after reset", len_err, 0);
  endtask

  task automatic t_backpressure();
    logic [511:0] e0;
    make_msg(64, 5);
    build_exp(64, 0);
    e0 = exp_block(0);
    nblk = 0;
    pulse_start(0);
    blk_ready = 1'b0;
    for (int i = 0; i < 64; i++) put(msg[i], 1'b1, 1'b0);
    chk(blk_valid == 1'b1, "R3", "blk_valid after 64 bytes", blk_valid, 1);
    chk(in_ready == 1'b0, "R3", "in_ready while block waits", in_ready, 0);
    repeat (6) @(negedge clk);
    #1;
    chk(blk_valid == 1'b1, "R3", "blk_valid held while not ready", blk_valid, 1);
    chk_blk(blk_data == e0, "R2", "held block packing", blk_data, e0);
    chk(nblk == 0, "R3", "no transfer while not ready", nblk, 0);
    @(negedge clk); blk_ready = 1'b1;
    send("backpressure", 0, 1'b0);
    wait_blocks("R3", "backpressure");
  endtask

  task automatic t_len_error();
    longint pre = 64'h1FFF_FFFF;
    make_msg(1, 9);
    build_exp(1, pre);
    nblk = 0;
    pulse_start(pre);
    #1;
    chk(len_err == 1'b0, "R10", "len_err before overflow byte", len_err, 0);
    put(msg[0], 1'b1, 1'b0);
    chk(len_err == 1'b1, "R10", "len_err after byte at max count", len_err, 1);
    send("len_error", 0, 1'b0);
    wait_blocks("R10", "len_error");
    chk(len_err == 1'b1, "R10", "len_err sticky through padding", len_err, 1);
    pulse_start(0);
    #1;
    chk(len_err == 1'b0, "R10", "len_err cleared by start", len_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_case("empty",       "R4",  0,  0, 1'b1, 1'b0, 1);
    run_case("three",       "R2",  3,  0, 1'b1, 1'b0, 2);
    run_case("mark_at_55",  "R6", 55,  0, 1'b1, 1'b0, 3);
    run_case("mark_at_56",  "R5", 56,  0, 1'b1, 1'b0, 4);
    run_case("full_block",  "R3", 64,  0, 1'b1, 1'b0, 6);
    run_case("together",    "R9",  5,  0, 1'b1, 1'b1, 7);
    run_case("no_start",    "R7", 10,  0, 1'b0, 1'b0, 8);
    run_case("preload_96",  "R8", 32, 96, 1'b1, 1'b0, 10);
    run_case("preload_odd", "R8", 70, 13, 1'b1, 1'b0, 11);
    t_backpressure();
    t_len_error();
    summary();
    $finish;
  end
endmodule